// File: doc/BRIEF.md
# TDM Serial Output Formatter

This block converts parallel audio samples into a time-division-multiplexed serial stream on four data lanes. The external bit clock drives it directly, and every register changes on the falling edge of that clock. A frame begins at the rising edge of the word-select input, after an optional polarity inversion. After a programmable number of bit clocks, the block sends a frame of up to 32 slots of up to 32 bits each. Each slot goes out MSB first.

Samples arrive from an upstream source over a valid/ready handshake. One beat carries one sample for every lane. A beat is consumed only at the start of a slot in which at least one lane's slot mask is set. A lane whose mask bit is clear sends the programmed mute word in that slot. Every sample and mute word is right-justified in its input field. The block takes the field's low bits up to the programmed MSB position and places them at the top of the slot, with zero padding below. A lane map routes each logical lane to a physical output pin. Separate output-side and input-side reset controls, together with an enable, gate all activity.

Configuration inputs must be held stable while the block is running. A new configuration is loaded by clearing the enable, asserting both resets, and then running the bring-up sequence again.

Top module: `tdm_out_formatter`

## Requirements
- R1: While `rst_n` is low, `cfg_enable` is low, or either `cfg_rst_out` or `cfg_rst_in` is high, the block is stopped. While stopped, `lane_o` is all zero, `smp_ready` is low, `underflow_o` is low, and word-select edges are ignored. The bring-up order is: set both resets, release `cfg_rst_out`, release `cfg_rst_in`, then set `cfg_enable`.
- R2: A frame starts at a falling bit-clock edge where the value `ws_i ^ cfg_ws_inv` is 1 and was 0 at the previous falling edge. The MSB of slot 0 appears on the lanes right after the falling edge that comes `cfg_skew` edges later. A skew of 0 means the same edge.
- R3: Each slot lasts `cfg_width_m1+1` bit clocks, and a frame has `cfg_slots_m1+1` slots. After the last bit of the last slot, every lane is low until the next frame start.
- R4: A slot carries bits `[cfg_msb_m1:0]` of its word, MSB first. The remaining `cfg_width_m1-cfg_msb_m1` bits of the slot are 0. The configuration must satisfy `cfg_msb_m1 <= cfg_width_m1`.
- R5: Bit `k` of `cfg_lane_mask[l*32 +: 32]` enables slot `k` on logical lane `l`. A disabled slot sends `cfg_mute`, justified as in R4.
- R6: `smp_ready` is high only in the bit period that ends at the start of a slot in which at least one logical lane's mask bit is set. One beat feeds every lane, and lane `l` takes `smp_data[l*32 +: 32]`. A slot with no lane enabled consumes no beat.
- R7: If `smp_valid` is low when an enabled slot starts, the enabled lanes send zeros for that slot. `underflow_o` then goes high and stays high until the block is stopped.
- R8: Physical lane `p` drives the logical lane whose number is in `cfg_lane_map[p*4 +: 4]`. A field value of 4 or more drives that pin low. The identity map is 16'h3210.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word-select / frame-sync input |
| cfg_enable | input | 1 | Run enable |
| cfg_rst_out | input | 1 | Output-side reset hold, active high |
| cfg_rst_in | input | 1 | Input-side reset hold, active high |
| cfg_ws_inv | input | 1 | Invert word select before frame-start detection |
| cfg_slots_m1 | input | 5 | Slots per frame minus one |
| cfg_width_m1 | input | 5 | Bits per slot minus one |
| cfg_msb_m1 | input | 5 | Sample width minus one |
| cfg_skew | input | 5 | Bit clocks from frame start to slot 0 MSB |
| cfg_lane_mask | input | 128 | Per-lane 32-bit slot enable masks |
| cfg_lane_map | input | 16 | Physical-to-logical lane map, 4 bits per pin |
| cfg_mute | input | 32 | Word sent in disabled slots |
| smp_valid | input | 1 | Sample beat valid |
| smp_data | input | 128 | One 32-bit sample per logical lane |
| smp_ready | output | 1 | Beat accepted at the next falling edge |
| lane_o | output | 4 | Serial data, one bit per physical lane |
| underflow_o | output | 1 | Sticky: an enabled slot started without a sample |

## Verification
A wrong slot or bit counter shows up on the lanes at the very next slot boundary. The faulty slot starts one bit early or late, and `smp_ready` pulses in the wrong bit period, so every later bit of the frame is misaligned. A lost or repeated handshake is visible in the data itself. Each beat carries a value derived from its beat number, so a skipped beat shifts every later sample on every enabled lane. A wrong skew or edge-detect state misplaces the first MSB of the frame, and that error appears within `cfg_skew+1` bit clocks of the frame-sync edge.

// File: rtl/tdm_out_pkg.sv
package tdm_out_pkg;
    localparam int unsigned TDM_DW        = 32;
    localparam int unsigned TDM_MAX_SLOTS = 32;
    localparam int unsigned TDM_LANES     = 4;
    localparam int unsigned TDM_MAP_W     = 4;
    localparam logic [TDM_LANES*TDM_MAP_W-1:0] TDM_MAP_IDENTITY = 16'h3210;
endpackage

// File: rtl/tdm_out_timer.sv
module tdm_out_timer #(
    parameter int unsigned DW        = tdm_out_pkg::TDM_DW,
    parameter int unsigned MAX_SLOTS = tdm_out_pkg::TDM_MAX_SLOTS,
    localparam int unsigned CNT_W    = $clog2(DW),
    localparam int unsigned SCNT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              ws_i,
    input  logic              ws_inv_i,
    input  logic [CNT_W-1:0]  skew_i,
    input  logic [SCNT_W-1:0] slots_m1_i,
    input  logic [CNT_W-1:0]  width_m1_i,
    output logic              load_o,
    output logic              clear_o,
    output logic [SCNT_W-1:0] slot_o
);
    typedef struct packed {
        logic              ws_prev;
        logic              wait_on;
        logic [CNT_W-1:0]  dly;
        logic              active;
        logic [CNT_W-1:0]  bit_cnt;
        logic [SCNT_W-1:0] slot;
    } timer_t;

    timer_t cur_q, nxt_d;
    logic   ws_eff, edge_hit, last_bit;

    always_comb begin
        nxt_d    = cur_q;
        load_o   = 1'b0;
        clear_o  = 1'b0;
        slot_o   = '0;
        ws_eff   = ws_i ^ ws_inv_i;
        edge_hit = run_i && ws_eff && !cur_q.ws_prev;
        last_bit = cur_q.active && (cur_q.bit_cnt == width_m1_i);
        nxt_d.ws_prev = ws_eff;
        if (!run_i) begin
            nxt_d.wait_on = 1'b0;
            nxt_d.dly     = '0;
            nxt_d.active  = 1'b0;
            nxt_d.bit_cnt = '0;
            nxt_d.slot    = '0;
            clear_o       = 1'b1;
        end else if (edge_hit) begin
            if (skew_i == '0) begin
                load_o = 1'b1;
            end else begin
                nxt_d.wait_on = 1'b1;
                nxt_d.dly     = skew_i;
                nxt_d.active  = 1'b0;
                nxt_d.bit_cnt = '0;
                nxt_d.slot    = '0;
                clear_o       = 1'b1;
            end
        end else begin
            if (cur_q.wait_on) begin
                if (cur_q.dly == CNT_W'(1)) begin
                    load_o = 1'b1;
                end else begin
                    nxt_d.dly = cur_q.dly - CNT_W'(1);
                end
            end
            if (last_bit) begin
                if (cur_q.slot == slots_m1_i) begin
                    nxt_d.active  = 1'b0;
                    nxt_d.bit_cnt = '0;
                    nxt_d.slot    = '0;
                    clear_o       = 1'b1;
                end else begin
                    load_o = 1'b1;
                    slot_o = cur_q.slot + SCNT_W'(1);
                end
            end else if (cur_q.active) begin
                nxt_d.bit_cnt = cur_q.bit_cnt + CNT_W'(1);
            end
        end
        if (load_o) begin
            nxt_d.wait_on = 1'b0;
            nxt_d.active  = 1'b1;
            nxt_d.bit_cnt = '0;
            nxt_d.slot    = slot_o;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_BIT_IN_SLOT: assert property (@(negedge bclk) disable iff (!rst_n)
        cur_q.active |-> (cur_q.bit_cnt <= width_m1_i)); // R3
    AST_SLOT_IN_FRAME: assert property (@(negedge bclk) disable iff (!rst_n)
        cur_q.active |-> (cur_q.slot <= slots_m1_i)); // R3
    AST_LOAD_STARTS_SLOT: assert property (@(negedge bclk) disable iff (!rst_n)
        load_o |=> (cur_q.active && cur_q.bit_cnt == '0)); // R3
    AST_HALT_WHEN_STOPPED: assert property (@(negedge bclk) disable iff (!rst_n)
        !run_i |=> (!cur_q.active && !cur_q.wait_on)); // R1
endmodule

// File: rtl/tdm_out_lane.sv
module tdm_out_lane #(
    parameter int unsigned DW = tdm_out_pkg::TDM_DW
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic [DW-1:0] word_i,
    output logic          bit_o
);
    logic [DW-1:0] sh_q, sh_d;

    always_comb begin
        if (load_i)       sh_d = word_i;
        else if (clear_i) sh_d = '0;
        else              sh_d = {sh_q[DW-2:0], 1'b0};
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[DW-1];

    AST_LOAD_SENDS_TOP: assert property (@(negedge bclk) disable iff (!rst_n)
        load_i |=> (bit_o == $past(word_i[DW-1]))); // R4
endmodule

// File: rtl/tdm_out_formatter.sv
module tdm_out_formatter #(
    parameter int unsigned LANES     = tdm_out_pkg::TDM_LANES,
    parameter int unsigned DW        = tdm_out_pkg::TDM_DW,
    parameter int unsigned MAX_SLOTS = tdm_out_pkg::TDM_MAX_SLOTS,
    parameter int unsigned MAP_W     = tdm_out_pkg::TDM_MAP_W,
    localparam int unsigned CNT_W    = $clog2(DW),
    localparam int unsigned SCNT_W   = $clog2(MAX_SLOTS)
) (
    input  logic                       bclk,
    input  logic                       rst_n,
    input  logic                       ws_i,
    input  logic                       cfg_enable,
    input  logic                       cfg_rst_out,
    input  logic                       cfg_rst_in,
    input  logic                       cfg_ws_inv,
    input  logic [SCNT_W-1:0]          cfg_slots_m1,
    input  logic [CNT_W-1:0]           cfg_width_m1,
    input  logic [CNT_W-1:0]           cfg_msb_m1,
    input  logic [CNT_W-1:0]           cfg_skew,
    input  logic [LANES*MAX_SLOTS-1:0] cfg_lane_mask,
    input  logic [LANES*MAP_W-1:0]     cfg_lane_map,
    input  logic [DW-1:0]              cfg_mute,
    input  logic                       smp_valid,
    input  logic [LANES*DW-1:0]        smp_data,
    output logic                       smp_ready,
    output logic [LANES-1:0]           lane_o,
    output logic                       underflow_o
);
    typedef struct packed {
        logic uf;
    } top_t;

    top_t              cur_q, nxt_d;
    logic              run, load, clear, need;
    logic [SCNT_W-1:0] slot_idx;
    logic [CNT_W-1:0]  sh_amt;
    logic [DW-1:0]     word  [LANES];
    logic [LANES-1:0]  ser_bit;

    assign run = cfg_enable && !cfg_rst_out && !cfg_rst_in;

    tdm_out_timer #(.DW(DW), .MAX_SLOTS(MAX_SLOTS)) u_timer (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .run_i      (run),
        .ws_i       (ws_i),
        .ws_inv_i   (cfg_ws_inv),
        .skew_i     (cfg_skew),
        .slots_m1_i (cfg_slots_m1),
        .width_m1_i (cfg_width_m1),
        .load_o     (load),
        .clear_o    (clear),
        .slot_o     (slot_idx)
    );

    always_comb begin
        logic [MAX_SLOTS-1:0] m;
        logic [DW-1:0]        raw;
        nxt_d  = cur_q;
        need   = 1'b0;
        sh_amt = CNT_W'(DW - 1) - cfg_msb_m1;
        for (int l = 0; l < LANES; l++) begin
            m = cfg_lane_mask[l*MAX_SLOTS +: MAX_SLOTS];
            if (m[slot_idx]) begin
                need = 1'b1;
                raw  = smp_valid ? smp_data[l*DW +: DW] : '0;
            end else begin
                raw  = cfg_mute;
            end
            word[l] = raw << sh_amt;
        end
        smp_ready = load && need;
        if (!run)                              nxt_d.uf = 1'b0;
        else if (load && need && !smp_valid)   nxt_d.uf = 1'b1;
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign underflow_o = cur_q.uf;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tdm_out_lane #(.DW(DW)) u_lane (
            .bclk    (bclk),
            .rst_n   (rst_n),
            .load_i  (load),
            .clear_i (clear),
            .word_i  (word[g]),
            .bit_o   (ser_bit[g])
        );
    end

    always_comb begin
        logic [MAP_W-1:0] sel;
        lane_o = '0;
        for (int p = 0; p < LANES; p++) begin
            sel = cfg_lane_map[p*MAP_W +: MAP_W];
            for (int l = 0; l < LANES; l++) begin
                if (sel == MAP_W'(l)) lane_o[p] = ser_bit[l];
            end
        end
    end

    AST_READY_NEEDS_RUN: assert property (@(negedge bclk) disable iff (!rst_n)
        smp_ready |-> run); // R6
    AST_UF_STICKY: assert property (@(negedge bclk) disable iff (!rst_n)
        (cur_q.uf && run) |=> cur_q.uf); // R7
    AST_LANES_LOW_STOPPED: assert property (@(negedge bclk) disable iff (!rst_n)
        !run |=> (lane_o == '0)); // R1
    AST_UF_CLEARED_STOPPED: assert property (@(negedge bclk) disable iff (!rst_n)
        !run |=> !underflow_o); // R1
endmodule

// File: tb/tdm_out_formatter_bench.sv
module tdm_out_formatter_bench;
    localparam int LANES = 4;
    localparam int DW    = 32;
    localparam int MS    = 32;

    logic bclk = 1'b0;
    always #10 bclk = ~bclk;

    logic                  rst_n = 1'b0;
    logic                  ws_i = 1'b0;
    logic                  cfg_enable = 1'b0, cfg_rst_out = 1'b1, cfg_rst_in = 1'b1, cfg_ws_inv = 1'b0;
    logic [4:0]            cfg_slots_m1 = '0, cfg_width_m1 = '0, cfg_msb_m1 = '0, cfg_skew = '0;
    logic [LANES*MS-1:0]   cfg_lane_mask = '0;
    logic [15:0]           cfg_lane_map = 16'h3210;
    logic [DW-1:0]         cfg_mute = '0;
    logic                  smp_valid = 1'b0;
    logic [LANES*DW-1:0]   smp_data = '0;
    logic                  smp_ready;
    logic [LANES-1:0]      lane_o;
    logic                  underflow_o;

    tdm_out_formatter u_tdm_out_formatter (
        .bclk(bclk), .rst_n(rst_n), .ws_i(ws_i),
        .cfg_enable(cfg_enable), .cfg_rst_out(cfg_rst_out), .cfg_rst_in(cfg_rst_in),
        .cfg_ws_inv(cfg_ws_inv), .cfg_slots_m1(cfg_slots_m1), .cfg_width_m1(cfg_width_m1),
        .cfg_msb_m1(cfg_msb_m1), .cfg_skew(cfg_skew), .cfg_lane_mask(cfg_lane_mask),
        .cfg_lane_map(cfg_lane_map), .cfg_mute(cfg_mute), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_ready(smp_ready), .lane_o(lane_o), .underflow_o(underflow_o)
    );

    int          errors = 0, checks = 0;
    bit          done = 1'b0;
    int unsigned beat = 0;
    int unsigned base = 0;
    bit          uf_model = 1'b0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] gen(int unsigned b, int l);
        return ((b + 32'd1) * 32'h9E3779B1) ^ (32'(l) * 32'h5A5A1234);
    endfunction

    function automatic bit any_mask(int k);
        for (int l = 0; l < LANES; l++) if (cfg_lane_mask[l*MS + k]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int count_before(int k);
        int n = 0;
        for (int s = 0; s < k; s++) if (any_mask(s)) n++;
        return n;
    endfunction

    // Expected serial bit on physical lane p, t bit clocks after frame start (R2 R3 R4 R5 R7 R8)
    function automatic bit exp_bit(int p, int t, bit uf);
        int sel, pos, w, s, k, j;
        logic [31:0] wd;
        sel = int'(cfg_lane_map[p*4 +: 4]);
        if (sel >= LANES) return 1'b0;
        w = int'(cfg_width_m1) + 1;
        s = int'(cfg_slots_m1) + 1;
        pos = t - int'(cfg_skew);
        if (pos < 0 || pos >= s*w) return 1'b0;
        k = pos / w;
        j = pos % w;
        if (j > int'(cfg_msb_m1)) return 1'b0;
        if (cfg_lane_mask[sel*MS + k]) wd = uf ? 32'd0 : gen(base + count_before(k), sel);
        else                           wd = cfg_mute;
        return wd[int'(cfg_msb_m1) - j];
    endfunction

    function automatic bit exp_ready(int c);
        int pos, w, s;
        w = int'(cfg_width_m1) + 1;
        s = int'(cfg_slots_m1) + 1;
        pos = c - int'(cfg_skew);
        if (pos < 0 || pos >= s*w || (pos % w) != 0) return 1'b0;
        return any_mask(pos / w);
    endfunction

    task automatic idle_check(string tag);
        chk(tag, 64'(lane_o), 64'd0);
        chk(tag, 64'(smp_ready), 64'd0);
        chk(tag, 64'(underflow_o), 64'd0);
    endtask

    // R1: fixed bring-up order; word-select pulses while held must do nothing
    task automatic bring_up();
        @(posedge bclk);
        cfg_enable = 1'b0; cfg_rst_out = 1'b1; cfg_rst_in = 1'b1; smp_valid = 1'b1;
        ws_i = cfg_ws_inv;
        repeat (2) @(posedge bclk);
        ws_i = ~cfg_ws_inv; #1 idle_check("R1 both resets held");
        @(posedge bclk); ws_i = cfg_ws_inv; cfg_rst_out = 1'b0;
        @(posedge bclk); ws_i = ~cfg_ws_inv; #1 idle_check("R1 input reset held");
        @(posedge bclk); ws_i = cfg_ws_inv; cfg_rst_in = 1'b0;
        @(posedge bclk); ws_i = ~cfg_ws_inv; #1 idle_check("R1 enable low");
        @(posedge bclk); ws_i = cfg_ws_inv;
        @(posedge bclk); cfg_enable = 1'b1;
        @(posedge bclk); #1 idle_check("R1 enabled before frame");
        uf_model = 1'b0;
        base = beat;
    endtask

    task automatic run_frame(int extra, bit long_ws, bit uf);
        int p_len, hi, w, s;
        w = int'(cfg_width_m1) + 1;
        s = int'(cfg_slots_m1) + 1;
        p_len = int'(cfg_skew) + s*w + 2 + extra;
        hi = long_ws ? p_len / 2 : 1;
        for (int c = 0; c < p_len; c++) begin
            @(posedge bclk);
            ws_i = (c < hi) ^ cfg_ws_inv;
            smp_valid = !uf;
            for (int l = 0; l < LANES; l++) smp_data[l*DW +: DW] = gen(beat, l);
            #1;
            if (c > 0) begin
                for (int p = 0; p < LANES; p++)
                    chk("R2 R3 R4 R5 R8 lane bit", 64'(lane_o[p]), 64'(exp_bit(p, c - 1, uf)));
            end else begin
                chk("R3 gap between frames", 64'(lane_o), 64'd0);
            end
            chk("R6 ready timing", 64'(smp_ready), 64'(exp_ready(c)));
            chk("R7 underflow flag", 64'(underflow_o), 64'(uf_model));
            if (uf && exp_ready(c)) uf_model = 1'b1;
            if (smp_valid && smp_ready) beat++;
        end
        if (!uf) base += count_before(s);
    endtask

    task automatic set_cfg(int slots, int width, int msb, int skew, bit inv,
                           logic [127:0] mask, logic [15:0] map, logic [31:0] mute);
        cfg_enable = 1'b0;
        @(posedge bclk);
        cfg_slots_m1 = 5'(slots - 1); cfg_width_m1 = 5'(width - 1); cfg_msb_m1 = 5'(msb - 1);
        cfg_skew = 5'(skew); cfg_ws_inv = inv; cfg_lane_mask = mask; cfg_lane_map = map;
        cfg_mute = mute;
        bring_up();
    endtask

    initial begin
        repeat (200000) @(posedge bclk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] map;
        logic [3:0]  tmp;
        int a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge bclk);
        #1 idle_check("R1 in reset");
        rst_n = 1'b1;

        // R2 R4: full 32-bit samples, all slots, skew 1
        set_cfg(8, 32, 32, 1, 1'b0, {128{1'b1}}, 16'h3210, 32'h0);
        run_frame(0, 1'b0, 1'b0);
        run_frame(3, 1'b1, 1'b0);
        // R2 R4: 16-bit samples in 16-bit slots, skew 2, inverted word select
        set_cfg(4, 16, 16, 2, 1'b1, {32'h5, 32'hA, 32'hF, 32'h3}, 16'h3210, 32'hFFFF_A5A5);
        run_frame(1, 1'b1, 1'b0);
        run_frame(0, 1'b0, 1'b0);
        // R3 R5: 32 slots of 8 bits, partial masks, padding below 6-bit sample
        set_cfg(32, 8, 6, 0, 1'b0, {32'h8000_0001, 32'h0F0F_0000, 32'h0000_FFFF, 32'h1234_5678},
                16'h3210, 32'h0000_002A);
        run_frame(2, 1'b0, 1'b0);
        // R6 R8: slots with no lane enabled, a dead pin, a swapped pin
        set_cfg(6, 12, 10, 3, 1'b0, {32'h0, 32'h9, 32'h0, 32'h21}, 16'hF102, 32'h0000_0155);
        run_frame(0, 1'b1, 1'b0);
        run_frame(2, 1'b0, 1'b0);
        // R7: sample source runs dry for a frame, then recovers
        set_cfg(4, 16, 16, 1, 1'b0, {32'h3, 32'h0, 32'h5, 32'h0}, 16'h3210, 32'h0000_0F0F);
        run_frame(0, 1'b0, 1'b1);
        run_frame(1, 1'b0, 1'b0);

        // Random configurations
        for (int n = 0; n < 14; n++) begin
            int slots, width, msb, skew;
            slots = 1 + int'($urandom() % 8);
            width = 8 + int'($urandom() % 25);
            msb   = 1 + int'($urandom() % width);
            skew  = int'($urandom() % 4);
            map = 16'h3210;
            for (int s = 0; s < 3; s++) begin
                a = int'($urandom() % 4); b = int'($urandom() % 4);
                tmp = map[a*4 +: 4]; map[a*4 +: 4] = map[b*4 +: 4]; map[b*4 +: 4] = tmp;
            end
            if (($urandom() % 4) == 0) map[($urandom() % 4)*4 +: 4] = 4'hF;
            set_cfg(slots, width, msb, skew, 1'($urandom()),
                    {$urandom(), $urandom(), $urandom(), $urandom()}, map, $urandom());
            for (int f = 0; f < 2; f++) run_frame(int'($urandom() % 4), 1'($urandom()), 1'b0);
        end

        // R1: disable mid-frame, lanes fall low
        set_cfg(8, 32, 32, 0, 1'b0, {128{1'b1}}, 16'h3210, 32'h0);
        @(posedge bclk); ws_i = 1'b1; smp_valid = 1'b1;
        repeat (5) @(posedge bclk);
        ws_i = 1'b0; cfg_enable = 1'b0;
        @(posedge bclk); #1 idle_check("R1 disabled mid-frame");
        repeat (3) @(posedge bclk);
        #1 idle_check("R1 stays stopped");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule